// File: doc/BRIEF.md
# Expected-Latency Request Steering Unit

This block sits in front of two memory request queues, one for a die-stacked DRAM cache and one for off-chip DRAM. For each incoming read it chooses one queue. It uses three inputs with the request: a flag saying the cache may hold a dirty copy of the line, a predicted hit/miss bit, and the bank the request would use in each memory.

Requests that may be dirty must be served by the cache. Requests predicted to miss go straight off-chip. A clean request predicted to hit is sent to the memory with the lower expected latency. The expected latency of a path is the number of requests already counted against the target bank in that memory, multiplied by a programmable per-request latency for that memory. Even cache hits can therefore be moved off-chip when the cache banks are congested, which lets both memories' bandwidth be used.

The block keeps one occupancy counter per bank for each memory. A counter goes up when a request is committed to that bank and goes down on that memory's completion pulse. The decision is registered and presented to the queues with a valid/ready handshake.

Top module: `mem_path_steer`

## Requirements
- R1: A request with `in_dirty` = 1 is always steered to the cache (`out_to_mem` = 0), whatever the prediction and the counts.
- R2: A request with `in_dirty` = 0 and `in_hit` = 0 is steered off-chip (`out_to_mem` = 1).
- R3: For a clean request predicted to hit, let Nc be the cache count of `in_cbank` and Nm the off-chip count of `in_mbank`. The request goes off-chip exactly when Nm·Lm < Nc·Lc, where Lc and Lm are the current cache and off-chip latency settings.
- R4: When Nm·Lm equals Nc·Lc, including when both counts are zero, a clean predicted hit goes to the cache.
- R5: When a request is accepted (`in_valid` and `in_ready` high at a clock edge), the counter of its target bank in the chosen memory is incremented, and only that counter. A `c_done`/`m_done` pulse decrements the counter of the named bank in that memory. Banks are independent.
- R6: A counter holds at 2^CNT_W−1 on further increments. A completion on a counter that is already zero is ignored.
- R7: An increment and a decrement of the same counter at the same edge leave it unchanged.
- R8: An accepted request appears on the outputs at the next edge. `out_bank` carries the chosen memory's bank. While `out_valid` is high and the chosen queue's ready is low, the outputs hold steady and `in_ready` is low. The other queue's ready has no effect on this.
- R9: A write with `cfg_we` = 1 sets Lc when `cfg_sel` = 0 and Lm when `cfg_sel` = 1. The new value is used for decisions from the next edge onward. After reset, Lc = LAT_C_RST and Lm = LAT_M_RST.
- R10: After reset, `out_valid` is low, `in_ready` is high and every counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Latency setting write strobe |
| cfg_sel | input | 1 | 0 selects cache latency, 1 selects off-chip latency |
| cfg_lat | input | LAT_W | Latency value to write |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted at this edge when high with in_valid |
| in_dirty | input | 1 | Cache may hold dirty data for this request |
| in_hit | input | 1 | Predicted cache hit |
| in_cbank | input | CB_W | Target bank in the cache |
| in_mbank | input | MB_W | Target bank off-chip |
| in_id | input | ID_W | Request tag carried through |
| out_valid | output | 1 | Steered request present |
| out_to_mem | output | 1 | 1 = off-chip queue, 0 = cache queue |
| out_bank | output | BK_W | Bank in the chosen memory |
| out_id | output | ID_W | Request tag |
| c_rdy | input | 1 | Cache queue can take a request |
| m_rdy | input | 1 | Off-chip queue can take a request |
| c_done | input | 1 | Cache completion pulse |
| c_done_bank | input | CB_W | Bank of the cache completion |
| m_done | input | 1 | Off-chip completion pulse |
| m_done_bank | input | MB_W | Bank of the off-chip completion |

## Verification
The bench builds the block with four banks per memory and 3-bit counters, so saturation at 7 is reached after a handful of requests. It uses 6-bit latencies with reset values 3 and 5, which makes small counts produce exact ties (for example 5·3 = 3·5) and single-count differences that flip the steering choice. A reference model of the counters and latency settings predicts every decision. The checks cover forced routing of dirty and missed requests, saturation, underflow, same-edge increment and decrement, backpressure from each queue separately, and a randomized stretch with random completions and random queue readiness.

// File: rtl/mem_path_steer.sv
module mem_path_steer #(
  parameter int NB_C = 8,
  parameter int NB_M = 8,
  parameter int CNT_W = 5,
  parameter int LAT_W = 8,
  parameter int ID_W = 6,
  parameter int LAT_C_RST = 6,
  parameter int LAT_M_RST = 14,
  localparam int CB_W = (NB_C > 1) ? $clog2(NB_C) : 1,
  localparam int MB_W = (NB_M > 1) ? $clog2(NB_M) : 1,
  localparam int BK_W = (CB_W > MB_W) ? CB_W : MB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [LAT_W-1:0]  cfg_lat,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_dirty,
  input  logic              in_hit,
  input  logic [CB_W-1:0]   in_cbank,
  input  logic [MB_W-1:0]   in_mbank,
  input  logic [ID_W-1:0]   in_id,
  output logic              out_valid,
  output logic              out_to_mem,
  output logic [BK_W-1:0]   out_bank,
  output logic [ID_W-1:0]   out_id,
  input  logic              c_rdy,
  input  logic              m_rdy,
  input  logic              c_done,
  input  logic [CB_W-1:0]   c_done_bank,
  input  logic              m_done,
  input  logic [MB_W-1:0]   m_done_bank
);
  localparam int E_W = CNT_W + LAT_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [LAT_W-1:0] lat_c, lat_m;
  logic [CNT_W-1:0] cnt_c [NB_C];
  logic [CNT_W-1:0] cnt_m [NB_M];
  logic [E_W-1:0]   exp_c, exp_m;
  logic             go_mem, accept, fire;

  assign exp_c  = E_W'(cnt_c[in_cbank]) * E_W'(lat_c);
  assign exp_m  = E_W'(cnt_m[in_mbank]) * E_W'(lat_m);
  assign go_mem = !in_dirty && (!in_hit || (exp_m < exp_c));

  assign fire     = out_valid && (out_to_mem ? m_rdy : c_rdy);
  assign in_ready = !out_valid || fire;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_c <= LAT_W'(LAT_C_RST);
      lat_m <= LAT_W'(LAT_M_RST);
    end else if (cfg_we) begin
      if (cfg_sel) lat_m <= cfg_lat;
      else         lat_c <= cfg_lat;
    end
  end

  for (genvar b = 0; b < NB_C; b++) begin : g_cache_cnt
    logic up, dn;
    assign up = accept && !go_mem && (in_cbank == CB_W'(b));
    assign dn = c_done && (c_done_bank == CB_W'(b));
    always_ff @(posedge clk) begin
      if (!rst_n)                                cnt_c[b] <= '0;
      else if (up && !dn && cnt_c[b] != CNT_MAX) cnt_c[b] <= cnt_c[b] + 1'b1;
      else if (dn && !up && cnt_c[b] != '0)      cnt_c[b] <= cnt_c[b] - 1'b1;
    end
  end

  for (genvar b = 0; b < NB_M; b++) begin : g_mem_cnt
    logic up, dn;
    assign up = accept && go_mem && (in_mbank == MB_W'(b));
    assign dn = m_done && (m_done_bank == MB_W'(b));
    always_ff @(posedge clk) begin
      if (!rst_n)                                cnt_m[b] <= '0;
      else if (up && !dn && cnt_m[b] != CNT_MAX) cnt_m[b] <= cnt_m[b] + 1'b1;
      else if (dn && !up && cnt_m[b] != '0)      cnt_m[b] <= cnt_m[b] - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_to_mem <= 1'b0;
      out_bank   <= '0;
      out_id     <= '0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_to_mem <= go_mem;
      out_bank   <= go_mem ? BK_W'(in_mbank) : BK_W'(in_cbank);
      out_id     <= in_id;
    end else if (fire) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/mem_path_steer_chk.sv
module mem_path_steer_chk #(
  parameter int ID_W = 6,
  parameter int NB_C = 8,
  parameter int NB_M = 8,
  localparam int CB_W = (NB_C > 1) ? $clog2(NB_C) : 1,
  localparam int MB_W = (NB_M > 1) ? $clog2(NB_M) : 1,
  localparam int BK_W = (CB_W > MB_W) ? CB_W : MB_W
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            in_dirty,
  input logic            in_hit,
  input logic [CB_W-1:0] in_cbank,
  input logic [MB_W-1:0] in_mbank,
  input logic            out_valid,
  input logic            out_to_mem,
  input logic [BK_W-1:0] out_bank,
  input logic [ID_W-1:0] out_id,
  input logic            c_rdy,
  input logic            m_rdy
);
  logic sel_ready;
  assign sel_ready = out_to_mem ? m_rdy : c_rdy;

  assert_dirty_to_cache_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_dirty |=> out_valid && !out_to_mem);

  assert_miss_offchip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_dirty && !in_hit |=> out_valid && out_to_mem);

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !sel_ready |=> out_valid && $stable(out_to_mem) && $stable(out_bank) && $stable(out_id));

  assert_block_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !sel_ready |-> !in_ready);

  assert_bank_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_bank == (out_to_mem ? BK_W'($past(in_mbank)) : BK_W'($past(in_cbank))));
endmodule

bind mem_path_steer mem_path_steer_chk #(.ID_W(ID_W), .NB_C(NB_C), .NB_M(NB_M)) u_chk (.*);

// File: tb/mem_path_steer_test.sv
module mem_path_steer_test;
  localparam int NB = 4, CW = 3, LW = 6, IW = 6, CMAX = 7;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_sel = 0;
  logic [LW-1:0] cfg_lat = '0;
  logic in_valid = 0, in_dirty = 0, in_hit = 0;
  logic [1:0] in_cbank = 0, in_mbank = 0, c_done_bank = 0, m_done_bank = 0;
  logic [IW-1:0] in_id = 0;
  logic c_rdy = 1, m_rdy = 1, c_done = 0, m_done = 0;
  logic in_ready, out_valid, out_to_mem;
  logic [1:0] out_bank;
  logic [IW-1:0] out_id;

  int compared = 0, mismatched = 0;
  int mc[NB], mm[NB];
  int lc = 3, lm = 5;
  bit rnd_rdy = 0;
  logic [8:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  mem_path_steer #(.NB_C(NB), .NB_M(NB), .CNT_W(CW), .LAT_W(LW), .ID_W(IW),
                   .LAT_C_RST(3), .LAT_M_RST(5)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_lat(cfg_lat),
    .in_valid(in_valid), .in_ready(in_ready), .in_dirty(in_dirty), .in_hit(in_hit),
    .in_cbank(in_cbank), .in_mbank(in_mbank), .in_id(in_id),
    .out_valid(out_valid), .out_to_mem(out_to_mem), .out_bank(out_bank), .out_id(out_id),
    .c_rdy(c_rdy), .m_rdy(m_rdy), .c_done(c_done), .c_done_bank(c_done_bank),
    .m_done(m_done), .m_done_bank(m_done_bank));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int step(input int v, input bit up, input bit dn);
    if (up && !dn && v < CMAX) return v + 1;
    if (dn && !up && v > 0) return v - 1;
    return v;
  endfunction

  task automatic model_edge(input bit acc, input bit tm, input int cb, input int mb,
                            input bit cd, input int cdb, input bit md, input int mdb);
    for (int b = 0; b < NB; b++) begin
      mc[b] = step(mc[b], acc && !tm && cb == b, cd && cdb == b);
      mm[b] = step(mm[b], acc && tm && mb == b, md && mdb == b);
    end
  endtask

  task automatic push(input bit d, input bit h, input int cb, input int mb, input int id,
                      input string req, input bit cd = 0, input int cdb = 0,
                      input bit md = 0, input int mdb = 0);
    bit tm;
    @(negedge clk);
    in_valid = 1; in_dirty = d; in_hit = h;
    in_cbank = 2'(cb); in_mbank = 2'(mb); in_id = IW'(id);
    if (rnd_rdy) begin c_rdy = 1'($urandom); m_rdy = 1'($urandom); end
    #1;
    while (!in_ready) begin
      @(negedge clk);
      if (rnd_rdy) begin c_rdy = 1'($urandom); m_rdy = 1'($urandom); end
      #1;
    end
    c_done = cd; c_done_bank = 2'(cdb); m_done = md; m_done_bank = 2'(mdb);
    tm = d ? 1'b0 : (!h ? 1'b1 : (mm[mb] * lm < mc[cb] * lc));
    exp_q.push_back({tm, tm ? 2'(mb) : 2'(cb), IW'(id)});
    tag_q.push_back(req);
    model_edge(1, tm, cb, mb, cd, cdb, md, mdb);
    @(negedge clk);
    in_valid = 0; c_done = 0; m_done = 0;
  endtask

  task automatic complete(input bit cd, input int cdb, input bit md, input int mdb);
    @(negedge clk);
    c_done = cd; c_done_bank = 2'(cdb); m_done = md; m_done_bank = 2'(mdb);
    model_edge(0, 0, 0, 0, cd, cdb, md, mdb);
    @(negedge clk);
    c_done = 0; m_done = 0;
  endtask

  task automatic set_lat(input bit sel, input int v);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_lat = LW'(v);
    @(negedge clk);
    cfg_we = 0;
    if (sel) lm = v; else lc = v;
  endtask

  initial begin : monitor
    logic [8:0] e;
    string t;
    forever begin
      @(negedge clk); #1;
      if (rst_n && out_valid && (out_to_mem ? m_rdy : c_rdy)) begin
        if (exp_q.size() == 0) chk(0, "R8 unexpected output", 1, 0);
        else begin
          e = exp_q.pop_front(); t = tag_q.pop_front();
          chk({out_to_mem, out_bank, out_id} == e, t, int'({out_to_mem, out_bank, out_id}), int'(e));
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    mismatched++; compared++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : main
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(out_valid == 0, "R10 out_valid after reset", out_valid, 0);
    chk(in_ready == 1, "R10 in_ready after reset", in_ready, 1);

    push(0, 1, 0, 0, 1, "R4 zero-count tie to cache");
    push(0, 1, 0, 0, 2, "R3 cache busier goes off-chip");
    push(0, 1, 0, 0, 3, "R3 off-chip costlier stays in cache");
    push(1, 0, 1, 1, 4, "R1 dirty miss to cache");
    push(1, 1, 0, 0, 5, "R1 dirty hit to cache");
    push(0, 0, 2, 2, 6, "R2 clean miss off-chip");
    push(0, 1, 2, 3, 7, "R5 bank independence");
    complete(1, 0, 0, 0);
    complete(1, 0, 1, 0);
    complete(1, 0, 0, 0);
    push(0, 1, 0, 0, 8, "R5 counts after completions");
    push(0, 1, 0, 1, 9, "R5 decisions track counts");

    for (int i = 0; i < 9; i++) push(1, 1, 3, 0, 10 + i, "R6 fill cache bank 3");
    push(0, 0, 0, 3, 19, "R2 seed off-chip bank 3");
    set_lat(1, 21);
    push(0, 1, 3, 3, 20, "R4 saturated tie 7x3 vs 1x21");
    set_lat(1, 10);
    push(0, 1, 3, 3, 21, "R9 new off-chip latency used");
    for (int i = 0; i < 6; i++) complete(1, 3, 0, 0);
    set_lat(0, 20);
    push(0, 1, 3, 3, 22, "R6 saturated count drained");
    complete(1, 2, 1, 1);
    complete(1, 2, 0, 0);
    push(0, 1, 2, 1, 23, "R6 underflow ignored");

    push(1, 0, 1, 0, 24, "R7 setup");
    push(1, 0, 1, 0, 25, "R7 same-edge inc and dec", 1, 1);
    set_lat(0, 1); set_lat(1, 1);
    push(0, 1, 1, 2, 26, "R7 count after same-edge update");

    @(negedge clk); c_rdy = 1; m_rdy = 0;
    push(0, 0, 0, 2, 40, "R8 held then released");
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1, "R8 held valid", out_valid, 1);
    chk(out_id == 40, "R8 held id", out_id, 40);
    chk(out_to_mem == 1, "R8 held route", out_to_mem, 1);
    chk(in_ready == 0, "R8 input blocked by off-chip queue", in_ready, 0);
    @(negedge clk); m_rdy = 1; c_rdy = 0;
    push(1, 0, 2, 0, 41, "R8 held on cache queue");
    repeat (2) @(negedge clk);
    #1;
    chk(in_ready == 0, "R8 input blocked by cache queue", in_ready, 0);
    chk(out_bank == 2, "R8 held cache bank", out_bank, 2);
    @(negedge clk); c_rdy = 1;

    set_lat(0, 3); set_lat(1, 5);
    rnd_rdy = 1;
    for (int i = 0; i < 60; i++)
      push(($urandom % 4) == 0, ($urandom % 4) != 0, $urandom % NB, $urandom % NB,
           i % 64, "R3 randomized steering",
           ($urandom % 2) == 0, $urandom % NB, ($urandom % 3) == 0, $urandom % NB);
    rnd_rdy = 0;
    @(negedge clk); c_rdy = 1; m_rdy = 1;
    n = 0;
    while (exp_q.size() != 0 && n < 20) begin @(negedge clk); n++; end
    chk(exp_q.size() == 0, "R8 all requests delivered", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule